// File: doc/BRIEF.md
# Serial Register Port Slave

This block lets an external controller read and write a small register file over a four-wire synchronous serial link. The wires are an active-low enable, a serial clock, a receive data line into the block and a transmit data line out of it. The block runs on a system clock at least eight times faster than the serial clock. All three serial inputs pass through a two-flop synchronizer, and edges are then found on the system clock.

While enable is low, the block counts rising edges of the serial clock and shifts in one receive bit, MSB first, on each of them. When enable rises, the count decides what happens. A count of exactly 8 is a byte access on the default register (address 0). A count of exactly 16 is a command byte followed by a data byte. In the command byte, the top bit selects read (1) or write (0) and the low six bits give the address. Any other count is discarded, and no register changes. The transmit line is enabled only while enable is low. It changes only after falling edges of the serial clock. The transmit pad itself is outside the block, so the block presents the transmit data and an output-enable that the pad uses to leave high impedance.

Top module: `scp_slave`

## Requirements
- R1: After reset, every register reads 0 and the transmit output-enable is low.
- R2: The transmit output-enable is high while enable is low and goes low within a few system clocks after enable rises; it is low whenever enable has been high for three or more system clocks.
- R3: Receive data is taken on each rising serial clock edge while enable is low, MSB first.
- R4: A 16-clock access whose command top bit (bit 7) is 0 writes the second byte into the register addressed by command bits 5:0, and only once enable has risen.
- R5: A 16-clock access whose command top bit is 1 changes no register. Transmit bits 8 to 15 carry the addressed register, MSB first, starting on the falling edge after the 8th bit.
- R6: From the fall of enable, transmit bits 0 to 7 carry the default register (address 0), MSB first. An 8-clock access writes the received byte into the default register.
- R7: An access with any rising-edge count other than 8 or 16 changes no register.
- R8: A write to an address at or above the register count (8 by default) changes no register, and a read of such an address returns 0.
- R9: While enable is low, the transmit bit holds between successive falling serial clock edges; it does not change around a rising edge.
- R10: During the data phase of a 16-clock write, the transmit bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en_n | input | 1 | Serial access enable, active low |
| port_sck | input | 1 | Serial clock |
| port_rxd | input | 1 | Serial data into the block |
| port_txd | output | 1 | Serial data out of the block |
| port_txd_oe | output | 1 | Drive enable for the transmit pad; low means high impedance |

## Verification
Every address is written with a distinct arithmetic pattern and read back. This separates a correct address decode from aliasing or a shifted address field. The bench sweeps burst lengths from 1 to 20 clocks and fills each burst with a write command. Only the 8 and 16 clock lengths may change state, which tells a true exact-count check apart from a threshold or a modulo test. Byte exchanges show that the old default value goes out while the new one comes in. Out-of-range addresses show that decoding uses the full six-bit field. Before and after each rising edge, the transmit bit and output-enable are sampled, which separates rising-edge updates from the required falling-edge updates.

// File: rtl/scp_pkg.sv
// Package scp_pkg: default sizes shared by the serial register port blocks.
// Assumes the command byte is as wide as the data byte.
package scp_pkg;
    parameter int unsigned SCP_DATA_W   = 8;  // bits per byte phase
    parameter int unsigned SCP_ADDR_W   = 6;  // address field in command byte
    parameter int unsigned SCP_NUM_REGS = 8;  // implemented registers
    parameter int unsigned SCP_SYNC     = 2;  // synchronizer depth
endpackage

// File: rtl/scp_sync.sv
// Module scp_sync: multi-stage synchronizer for a bundle of asynchronous
// inputs. Assumes each input is stable long enough to be seen (the serial
// clock is slow relative to clk). Resets to RST_VAL.
module scp_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/scp_regfile.sv
// Module scp_regfile: small register file with one write port, one
// addressed read port and a fixed read of register 0. Addresses at or
// beyond NUM_REGS are not implemented: writes are dropped, reads give 0.
module scp_regfile #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] def_data
);
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic wr_ok;
    logic rd_ok;

    assign wr_ok = ({1'b0, wr_addr} < LIMIT);
    assign rd_ok = ({1'b0, rd_addr} < LIMIT);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Store the write data into register g when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_ok && (wr_addr == ADDR_W'(g)))
                regs[g] <= wr_data;
        end
    end

    // Addressed read, zero for unimplemented addresses.
    always_comb begin
        rd_data = '0;
        if (rd_ok) rd_data = regs[rd_addr[IDX_W-1:0]];
    end

    assign def_data = regs[0];

    // Registers change only on a commit strobe.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));
endmodule

// File: rtl/scp_engine.sv
// Module scp_engine: serial protocol engine. Works on synchronized inputs,
// detects serial clock edges, counts rising edges per enable-low window,
// shifts receive data MSB first, drives transmit data after falling edges,
// and issues a one-cycle commit when enable rises after exactly DATA_W or
// exactly 2*DATA_W rising edges. Assumes clk is at least 8x the serial clock.
module scp_engine #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              sck_s,
    input  logic              rxd_s,
    input  logic [DATA_W-1:0] def_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              txd_oe
);
    localparam int unsigned SR_W  = 2 * DATA_W;
    localparam int unsigned CNT_W = $clog2(SR_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(SR_W);

    logic              sck_q;
    logic              en_q;
    logic              rise;
    logic              fall;
    logic              en_rise;
    logic [CNT_W-1:0]  cnt;
    logic [SR_W-1:0]   rx_sr;
    logic [DATA_W-1:0] tx_sr;

    assign rise    = sck_s & ~sck_q & ~en_s;
    assign fall    = ~sck_s & sck_q & ~en_s;
    assign en_rise = en_s & ~en_q;

    // Edge-detect history of serial clock and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            en_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            en_q  <= en_s;
        end
    end

    // Count rising edges in the window, saturating; clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (en_s)                  cnt <= '0;
        else if (rise && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Shift receive data in on rising edges, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_sr <= '0;
        else if (rise) rx_sr <= {rx_sr[SR_W-2:0], rxd_s};
    end

    // Commit a write on enable rise when the count is a valid length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= en_rise && ((cnt == CNT_BYTE) ||
                                   ((cnt == CNT_WORD) && !rx_sr[SR_W-1]));
            wr_addr <= (cnt == CNT_BYTE) ? '0 : rx_sr[DATA_W+ADDR_W-1:DATA_W];
            wr_data <= rx_sr[DATA_W-1:0];
        end
    end

    assign rd_addr = rx_sr[ADDR_W-1:0];

    // Transmit shifter: preload default data idle, shift on falling edges,
    // reload with addressed data after the command byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sr <= '0;
        else if (en_s)
            tx_sr <= def_data;
        else if (fall) begin
            if (cnt == CNT_BYTE)
                tx_sr <= rx_sr[DATA_W-1] ? rd_data : '0;
            else
                tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
    end

    assign txd    = tx_sr[DATA_W-1];
    assign txd_oe = ~en_s;

    // A commit is a single-cycle strobe.
    assert_commit_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // The bit counter advances by at most one per cycle inside a window.
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !$past(en_s)) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // Transmit bit only changes after a falling serial clock edge.
    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !$past(en_s) && !$past(fall)) |-> $stable(txd));
endmodule

// File: rtl/scp_slave.sv
// Module scp_slave: serial register port slave top. Synchronizes the
// enable, serial clock and receive pins, runs the protocol engine and holds
// the register file. The transmit pad is driven from port_txd and enabled by
// port_txd_oe. Assumes clk runs at least 8x the serial clock.
module scp_slave #(
    parameter int unsigned DATA_W   = scp_pkg::SCP_DATA_W,
    parameter int unsigned ADDR_W   = scp_pkg::SCP_ADDR_W,
    parameter int unsigned NUM_REGS = scp_pkg::SCP_NUM_REGS,
    parameter int unsigned SYNC     = scp_pkg::SCP_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en_n,
    input  logic port_sck,
    input  logic port_rxd,
    output logic port_txd,
    output logic port_txd_oe
);
    logic              en_s;
    logic              sck_s;
    logic              rxd_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] def_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    scp_sync #(.WIDTH(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({port_en_n, port_sck, port_rxd}),
        .q     ({en_s, sck_s, rxd_s})
    );

    scp_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_s     (en_s),
        .sck_s    (sck_s),
        .rxd_s    (rxd_s),
        .def_data (def_data),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .txd      (port_txd),
        .txd_oe   (port_txd_oe)
    );

    scp_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .def_data (def_data)
    );

    // Transmit stays released once enable has been high for a while.
    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en_n && $past(port_en_n) && $past(port_en_n, 2) && $past(port_en_n, 3))
        |-> !port_txd_oe);
endmodule

// File: tb/scp_slave_test.sv
// Bench scp_slave_test: drives serial accesses at 1/16 of the system clock
// and checks register contents and transmit data against a bench model.
module scp_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b1;
    logic sck = 1'b0;
    logic rxd = 1'b0;
    logic txd;
    logic txd_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] model [8];

    always #2.5 clk = ~clk;

    scp_slave uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_en_n   (en_n),
        .port_sck    (sck),
        .port_rxd    (rxd),
        .port_txd    (txd),
        .port_txd_oe (txd_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One access of n serial clocks; bits taken from pat MSB first.
    // cap holds the transmit bit sampled before each rising edge, MSB first.
    task automatic xfer(input int n, input logic [31:0] pat, output logic [31:0] cap);
        bit oe_bad;
        bit hold_bad;
        logic pre;
        cap = '0;
        oe_bad = 1'b0;
        hold_bad = 1'b0;
        wait_cyc(2);
        en_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            rxd = (i < 32) ? pat[31-i] : 1'b0;
            wait_cyc(8);
            pre = txd;
            if (i < 32) cap[31-i] = txd;
            if (txd_oe !== 1'b1) oe_bad = 1'b1;
            sck = 1'b1;
            wait_cyc(6);
            if (txd !== pre) hold_bad = 1'b1;
            wait_cyc(2);
            sck = 1'b0;
        end
        wait_cyc(8);
        en_n = 1'b1;
        wait_cyc(8);
        chk("R2 oe during access", {31'd0, oe_bad}, 32'd0);
        chk("R2 oe released after enable", {31'd0, txd_oe}, 32'd0);
        chk("R9 txd held across rising edge", {31'd0, hold_bad}, 32'd0);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        logic [31:0] cap;
        xfer(16, {2'b00, a, d, 16'h0}, cap);
        chk("R10 write data phase txd", {24'd0, cap[23:16]}, 32'd0);
        if (a < 6'd8) model[a[2:0]] = d;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [7:0] v, output logic [7:0] c);
        logic [31:0] cap;
        xfer(16, {2'b10, a, 8'h00, 16'h0}, cap);
        v = cap[23:16];
        c = cap[31:24];
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] c;
        logic [31:0] cap;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 oe low after reset", {31'd0, txd_oe}, 32'd0);

        // R1: all registers zero after reset.
        for (int a = 0; a < 8; a++) begin
            do_read(6'(a), v, c);
            chk("R1 reset value", {24'd0, v}, 32'd0);
        end

        // R4/R5/R3: write each address with a distinct pattern, read all back.
        for (int a = 0; a < 8; a++) do_write(6'(a), 8'((a * 37 + 5) ^ 8'h5A));
        for (int a = 0; a < 8; a++) begin
            do_read(6'(a), v, c);
            chk("R4 R5 readback", {24'd0, v}, {24'd0, model[a]});
            chk("R6 command phase shows default", {24'd0, c}, {24'd0, model[0]});
        end

        // R6: byte exchange on the default register.
        for (int k = 0; k < 4; k++) begin
            logic [7:0] nv;
            nv = 8'(8'h81 + k * 8'h3B);
            xfer(8, {nv, 24'h0}, cap);
            chk("R6 byte read old", {24'd0, cap[31:24]}, {24'd0, model[0]});
            model[0] = nv;
            do_read(6'd0, v, c);
            chk("R6 byte write new", {24'd0, v}, {24'd0, nv});
        end

        // R7: every other burst length leaves registers untouched.
        for (int n = 1; n <= 20; n++) begin
            if (n != 8 && n != 16) begin
                xfer(n, {8'h03, 8'hA5, 8'hC3, 8'h3C}, cap);
                do_read(6'd3, v, c);
                chk("R7 discarded burst reg3", {24'd0, v}, {24'd0, model[3]});
                chk("R7 discarded burst reg0", {24'd0, c}, {24'd0, model[0]});
            end
        end

        // R8: unimplemented addresses.
        do_write(6'd9, 8'hE7);
        do_write(6'd63, 8'h11);
        do_read(6'd1, v, c);
        chk("R8 no alias on reg1", {24'd0, v}, {24'd0, model[1]});
        do_read(6'd7, v, c);
        chk("R8 no alias on reg7", {24'd0, v}, {24'd0, model[7]});
        do_read(6'd9, v, c);
        chk("R8 read unimplemented", {24'd0, v}, 32'd0);

        // R5: a read changes nothing.
        do_read(6'd2, v, c);
        do_read(6'd2, v, c);
        chk("R5 read is non-destructive", {24'd0, v}, {24'd0, model[2]});

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule